// File: doc/BRIEF.md
# Shared Leading-Zero Fragment Color Compressor

This block shortens the colour of one transparent fragment before it is written into a per-pixel fragment store. It reads the 8-bit red, green and blue components and counts the leading zeros of each. It takes the smallest of the three counts and removes that many top bits from every component. It then shifts all three components right by an amount set by the fragment's alpha, because a faint fragment contributes only its upper colour bits to the blended pixel. The result is three fields of equal width, packed side by side. A 4-bit length code gives the width of one field, and the store keeps these codes in a length table with one entry per storage section.

A matching restore path takes the packed bits, the length code and the fragment's alpha. It rebuilds the three 8-bit components: each field is moved back up by the alpha shift, with zeros filling the low bits. Both paths are valid/ready streams. Each path has one register stage that is run by a two-state controller. The controller states are EMPTY and FULL. The transitions are:

- LOAD takes EMPTY to FULL when an input is offered.
- DRAIN takes FULL to EMPTY when the output is taken and no new input arrives.
- REFILL keeps the stage in FULL when the output is taken and a new input is accepted in the same cycle.
- STALL keeps the stage in FULL while the output is refused.

Top module: `lzc_top`

## Requirements
- R1: The shared elimination count E is the minimum of the leading-zero counts of R, G and B. A component equal to zero counts 8 leading zeros. With alpha shift S, the length code is 8−E−S, or 0 when E+S ≥ 8. The code is therefore always in the range 0 to 8.
- R2: The alpha shift S is computed from the 8-bit alpha A, whose highest set bit is at position m. S is 8−m when A is an exact power of two and 7−m otherwise. For example, A=0x20 gives 3, A=0x80 gives 1, A=0x90 gives 0, A=0xFF gives 0 and A=0x01 gives 8.
- R3: An alpha of zero yields a length code of 0 and packed bits of 0, whatever the colour.
- R4: With length code L, the packed word holds B>>S in bits [L−1:0], G>>S in bits [2L−1:L] and R>>S in bits [3L−1:2L]. All bits from position 3L upward are zero.
- R5: The restore path extracts each L-bit field, shifts it left by S (computed from its alpha input as in R2) and truncates the result to 8 bits. Field positions are those of R4.
- R6: The compress path has a latency of one cycle. A fragment accepted at a clock edge is presented on the output from that edge on. With the output always taken, the path accepts one fragment every cycle.
- R7: While the compressed output is valid and refused, the output contents stay unchanged and the input ready signal is low. A fragment offered during the stall is taken only when the output is taken.
- R8: During and directly after reset, both output valid signals are low and both input ready signals are high.
- R9: The restore path has the same one-cycle, one-per-cycle handshake. It holds its output stable while that output is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_in_valid | input | 1 | Fragment offered for compression |
| c_in_ready | output | 1 | Compress stage can take a fragment |
| c_in_r | input | 8 | Red component |
| c_in_g | input | 8 | Green component |
| c_in_b | input | 8 | Blue component |
| c_in_a | input | 8 | Alpha |
| c_out_valid | output | 1 | Compressed fragment available |
| c_out_ready | input | 1 | Consumer takes compressed fragment |
| c_out_bits | output | 24 | Packed shortened colour, LSB-aligned |
| c_out_len | output | 4 | Per-component length code for the section table |
| c_out_a | output | 8 | Alpha carried alongside the packed colour |
| d_in_valid | input | 1 | Packed fragment offered for restore |
| d_in_ready | output | 1 | Restore stage can take a fragment |
| d_in_bits | input | 24 | Packed colour read from the store |
| d_in_len | input | 4 | Length code read from the section table |
| d_in_a | input | 8 | Alpha of the stored fragment |
| d_out_valid | output | 1 | Restored colour available |
| d_out_ready | input | 1 | Consumer takes restored colour |
| d_out_r | output | 8 | Restored red |
| d_out_g | output | 8 | Restored green |
| d_out_b | output | 8 | Restored blue |

## Verification
The hardest case to reach is REFILL under a stall. In that case the output has been refused for several cycles while a second fragment waits at the input. The first fragment must leave and the second must enter on the same edge, and neither may be lost or duplicated. The bench builds this case directly. It holds the output ready low, loads one fragment and offers a second. It checks that the input ready stays low and the held output stays unchanged. It then raises the output ready and expects the second fragment to appear one edge later. The arithmetic corners are the alpha boundaries: zero alpha, exact powers of two, and an alpha just above a power of two. Further corners are an all-zero colour and the case where the elimination count and the shift together reach 8. These are placed in the vector table.

// File: rtl/lzc_pkg.sv
package lzc_pkg;

    localparam int COMP_W   = 8;
    localparam int LEN_W    = 4;
    localparam int PACK_W   = 3 * COMP_W;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_e;

    // Leading zeros of a component; a zero component counts COMP_W.
    function automatic logic [LEN_W-1:0] lead_zeros(input logic [COMP_W-1:0] v);
        logic [LEN_W-1:0] n;
        logic             seen;
        n    = '0;
        seen = 1'b0;
        for (int i = COMP_W - 1; i >= 0; i--) begin
            if (!seen && !v[i]) begin
                n = n + 1'b1;
            end else begin
                seen = 1'b1;
            end
        end
        return n;
    endfunction

    // Right shift implied by alpha: floor(-log2(A/2^COMP_W)), zero alpha -> COMP_W.
    function automatic logic [LEN_W-1:0] alpha_shift(input logic [COMP_W-1:0] a);
        logic [LEN_W-1:0] top;
        logic             pow2;
        logic [LEN_W-1:0] res;
        top  = '0;
        for (int i = 0; i < COMP_W; i++) begin
            if (a[i]) top = LEN_W'(i);
        end
        pow2 = ((a & (a - 1'b1)) == '0);
        if (a == '0) begin
            res = LEN_W'(COMP_W);
        end else if (pow2) begin
            res = LEN_W'(COMP_W) - top;
        end else begin
            res = LEN_W'(COMP_W - 1) - top;
        end
        return res;
    endfunction

endpackage

// File: rtl/lzc_pack.sv
module lzc_pack
    import lzc_pkg::*;
(
    input  logic [COMP_W-1:0] r,
    input  logic [COMP_W-1:0] g,
    input  logic [COMP_W-1:0] b,
    input  logic [COMP_W-1:0] a,
    output logic [PACK_W-1:0] bits,
    output logic [LEN_W-1:0]  len
);

    logic [LEN_W-1:0]  lz_r, lz_g, lz_b;
    logic [LEN_W-1:0]  elim;
    logic [LEN_W-1:0]  shamt;
    logic [LEN_W:0]    total;
    logic [PACK_W-1:0] fr, fg, fb;
    logic [PACK_W-1:0] mask;

    always_comb begin
        lz_r  = lead_zeros(r);
        lz_g  = lead_zeros(g);
        lz_b  = lead_zeros(b);
        elim  = lz_r;
        if (lz_g < elim) elim = lz_g;
        if (lz_b < elim) elim = lz_b;
        shamt = alpha_shift(a);
        total = {1'b0, elim} + {1'b0, shamt};
        if (total >= (LEN_W+1)'(COMP_W)) begin
            len = '0;
        end else begin
            len = LEN_W'((LEN_W+1)'(COMP_W) - total);
        end
        mask = (PACK_W'(1) << len) - PACK_W'(1);
        fr   = PACK_W'(r >> shamt) & mask;
        fg   = PACK_W'(g >> shamt) & mask;
        fb   = PACK_W'(b >> shamt) & mask;
        bits = (fr << (2 * len)) | (fg << len) | fb;
    end

endmodule

// File: rtl/lzc_unpack.sv
module lzc_unpack
    import lzc_pkg::*;
(
    input  logic [PACK_W-1:0] bits,
    input  logic [LEN_W-1:0]  len,
    input  logic [COMP_W-1:0] a,
    output logic [COMP_W-1:0] r,
    output logic [COMP_W-1:0] g,
    output logic [COMP_W-1:0] b
);

    logic [LEN_W-1:0]  shamt;
    logic [LEN_W-1:0]  l;
    logic [PACK_W-1:0] mask;
    logic [PACK_W-1:0] fr, fg, fb;

    always_comb begin
        shamt = alpha_shift(a);
        l     = (len > LEN_W'(COMP_W)) ? LEN_W'(COMP_W) : len;
        mask  = (PACK_W'(1) << l) - PACK_W'(1);
        fb    = bits & mask;
        fg    = (bits >> l) & mask;
        fr    = (bits >> (2 * l)) & mask;
        r     = COMP_W'(fr << shamt);
        g     = COMP_W'(fg << shamt);
        b     = COMP_W'(fb << shamt);
    end

endmodule

// File: rtl/lzc_stage.sv
module lzc_stage
    import lzc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);

    stage_state_e     state_q, state_d;
    logic [WIDTH-1:0] data_q;
    logic             take;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid) state_d = ST_FULL;          // LOAD
            end
            ST_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                if (out_ready && !in_valid) state_d = ST_EMPTY; // DRAIN
                else                        state_d = ST_FULL;  // REFILL / STALL
            end
            default: state_d = ST_EMPTY;
        endcase
        take = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (take) begin
            data_q <= in_data;
        end
    end

    assign out_data = data_q;

endmodule

// File: rtl/lzc_top.sv
module lzc_top
    import lzc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        c_in_valid,
    output logic        c_in_ready,
    input  logic [7:0]  c_in_r,
    input  logic [7:0]  c_in_g,
    input  logic [7:0]  c_in_b,
    input  logic [7:0]  c_in_a,
    output logic        c_out_valid,
    input  logic        c_out_ready,
    output logic [23:0] c_out_bits,
    output logic [3:0]  c_out_len,
    output logic [7:0]  c_out_a,
    input  logic        d_in_valid,
    output logic        d_in_ready,
    input  logic [23:0] d_in_bits,
    input  logic [3:0]  d_in_len,
    input  logic [7:0]  d_in_a,
    output logic        d_out_valid,
    input  logic        d_out_ready,
    output logic [7:0]  d_out_r,
    output logic [7:0]  d_out_g,
    output logic [7:0]  d_out_b
);

    localparam int CW = PACK_W + LEN_W + COMP_W;
    localparam int DW = PACK_W;

    logic [PACK_W-1:0] pk_bits;
    logic [LEN_W-1:0]  pk_len;
    logic [CW-1:0]     c_data;
    logic [COMP_W-1:0] up_r, up_g, up_b;
    logic [DW-1:0]     d_data;

    lzc_pack u_pack (
        .r    (c_in_r),
        .g    (c_in_g),
        .b    (c_in_b),
        .a    (c_in_a),
        .bits (pk_bits),
        .len  (pk_len)
    );

    lzc_stage #(.WIDTH(CW)) u_cstage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (c_in_valid),
        .in_ready  (c_in_ready),
        .in_data   ({pk_bits, pk_len, c_in_a}),
        .out_valid (c_out_valid),
        .out_ready (c_out_ready),
        .out_data  (c_data)
    );

    assign c_out_bits = c_data[CW-1 -: PACK_W];
    assign c_out_len  = c_data[COMP_W +: LEN_W];
    assign c_out_a    = c_data[COMP_W-1:0];

    lzc_unpack u_unpack (
        .bits (d_in_bits),
        .len  (d_in_len),
        .a    (d_in_a),
        .r    (up_r),
        .g    (up_g),
        .b    (up_b)
    );

    lzc_stage #(.WIDTH(DW)) u_dstage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (d_in_valid),
        .in_ready  (d_in_ready),
        .in_data   ({up_r, up_g, up_b}),
        .out_valid (d_out_valid),
        .out_ready (d_out_ready),
        .out_data  (d_data)
    );

    assign d_out_r = d_data[23:16];
    assign d_out_g = d_data[15:8];
    assign d_out_b = d_data[7:0];

endmodule

// File: rtl/lzc_chk.sv
module lzc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        c_in_valid,
    input logic        c_in_ready,
    input logic        c_out_valid,
    input logic        c_out_ready,
    input logic [23:0] c_out_bits,
    input logic [3:0]  c_out_len,
    input logic        d_in_valid,
    input logic        d_in_ready,
    input logic        d_out_valid,
    input logic        d_out_ready,
    input logic [7:0]  d_out_r
);

    // R1
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_out_valid |-> (c_out_len <= 4'd8));

    // R4
    pack_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_out_valid |-> ((32'(c_out_bits) >> (3 * c_out_len)) == 32'd0));

    // R6
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_in_valid && c_in_ready) |=> c_out_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_out_valid && !c_out_ready) |=> (c_out_valid && $stable(c_out_bits) && $stable(c_out_len)));

    // R7
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_out_valid && !c_out_ready) |-> !c_in_ready);

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!c_out_valid && !d_out_valid));

    // R9
    d_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_out_valid && !d_out_ready) |=> (d_out_valid && $stable(d_out_r)));

    // R9
    d_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_in_valid && d_in_ready) |=> d_out_valid);

endmodule

bind lzc_top lzc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .c_in_valid  (c_in_valid),
    .c_in_ready  (c_in_ready),
    .c_out_valid (c_out_valid),
    .c_out_ready (c_out_ready),
    .c_out_bits  (c_out_bits),
    .c_out_len   (c_out_len),
    .d_in_valid  (d_in_valid),
    .d_in_ready  (d_in_ready),
    .d_out_valid (d_out_valid),
    .d_out_ready (d_out_ready),
    .d_out_r     (d_out_r)
);

// File: tb/tb_lzc_top.sv
module tb_lzc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c_in_valid = 1'b0;
    logic        c_in_ready;
    logic [7:0]  c_in_r = '0, c_in_g = '0, c_in_b = '0, c_in_a = '0;
    logic        c_out_valid;
    logic        c_out_ready = 1'b1;
    logic [23:0] c_out_bits;
    logic [3:0]  c_out_len;
    logic [7:0]  c_out_a;
    logic        d_in_valid = 1'b0;
    logic        d_in_ready;
    logic [23:0] d_in_bits = '0;
    logic [3:0]  d_in_len = '0;
    logic [7:0]  d_in_a = '0;
    logic        d_out_valid;
    logic        d_out_ready = 1'b1;
    logic [7:0]  d_out_r, d_out_g, d_out_b;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    lzc_top dut (.*);

    // r, g, b, a, len, bits, restored r, g, b
    localparam int NV = 10;
    localparam logic [83:0] VEC [NV] = '{
        {8'h1F, 8'h0A, 8'h03, 8'h20, 4'd2, 24'h000034, 8'h18, 8'h08, 8'h00},
        {8'h3A, 8'h10, 8'h05, 8'h20, 4'd3, 24'h0001D0, 8'h38, 8'h10, 8'h00},
        {8'hFF, 8'h00, 8'h80, 8'hFF, 4'd8, 24'hFF0080, 8'hFF, 8'h00, 8'h80},
        {8'h00, 8'h00, 8'h00, 8'hFF, 4'd0, 24'h000000, 8'h00, 8'h00, 8'h00},
        {8'hFF, 8'h12, 8'h34, 8'h00, 4'd0, 24'h000000, 8'h00, 8'h00, 8'h00},
        {8'h40, 8'h21, 8'h7F, 8'h80, 4'd6, 24'h02043F, 8'h40, 8'h20, 8'h7E},
        {8'h01, 8'h02, 8'h03, 8'h90, 4'd2, 24'h00001B, 8'h01, 8'h02, 8'h03},
        {8'hFF, 8'hFF, 8'hFF, 8'h01, 4'd0, 24'h000000, 8'h00, 8'h00, 8'h00},
        {8'h80, 8'h0C, 8'h07, 8'h20, 4'd5, 24'h004020, 8'h80, 8'h08, 8'h00},
        {8'h0F, 8'h00, 8'h00, 8'h10, 4'd0, 24'h000000, 8'h00, 8'h00, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                tests++;
                fails++;
                $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 c_out_valid in reset", 32'(c_out_valid), 0);
        check("R8 c_in_ready in reset", 32'(c_in_ready), 1);
        check("R8 d_out_valid in reset", 32'(d_out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 c_out_valid after reset", 32'(c_out_valid), 0);

        // R1 R2 R3 R4 R5: vector table
        for (int i = 0; i < NV; i++) begin
            {c_in_r, c_in_g, c_in_b, c_in_a} = VEC[i][83:52];
            c_in_valid = 1'b1;
            @(negedge clk);
            c_in_valid = 1'b0;
            check("R6 c_out_valid one cycle", 32'(c_out_valid), 1);
            check("R1 R2 R3 length code", 32'(c_out_len), 32'(VEC[i][51:48]));
            check("R4 packed bits", 32'(c_out_bits), 32'(VEC[i][47:24]));
            d_in_bits  = VEC[i][47:24];
            d_in_len   = VEC[i][51:48];
            d_in_a     = VEC[i][59:52];
            d_in_valid = 1'b1;
            @(negedge clk);
            d_in_valid = 1'b0;
            check("R9 d_out_valid one cycle", 32'(d_out_valid), 1);
            check("R5 restored colour", 32'({d_out_r, d_out_g, d_out_b}), 32'(VEC[i][23:0]));
        end
        @(negedge clk);
        check("R6 c_out_valid drains", 32'(c_out_valid), 0);

        // R6: back-to-back throughput
        {c_in_r, c_in_g, c_in_b, c_in_a} = VEC[0][83:52];
        c_in_valid = 1'b1;
        @(negedge clk);
        check("R6 first of pair", 32'(c_out_bits), 32'(VEC[0][47:24]));
        check("R6 ready while streaming", 32'(c_in_ready), 1);
        {c_in_r, c_in_g, c_in_b, c_in_a} = VEC[5][83:52];
        @(negedge clk);
        c_in_valid = 1'b0;
        check("R6 second of pair", 32'(c_out_bits), 32'(VEC[5][47:24]));
        @(negedge clk);

        // R7: stall with a second fragment waiting (REFILL)
        c_out_ready = 1'b0;
        {c_in_r, c_in_g, c_in_b, c_in_a} = VEC[1][83:52];
        c_in_valid = 1'b1;
        @(negedge clk);
        {c_in_r, c_in_g, c_in_b, c_in_a} = VEC[8][83:52];
        check("R7 ready low during stall", 32'(c_in_ready), 0);
        @(negedge clk);
        @(negedge clk);
        check("R7 output held", 32'(c_out_bits), 32'(VEC[1][47:24]));
        check("R7 length held", 32'(c_out_len), 32'(VEC[1][51:48]));
        c_out_ready = 1'b1;
        @(negedge clk);
        c_in_valid = 1'b0;
        check("R7 waiting fragment follows", 32'(c_out_bits), 32'(VEC[8][47:24]));
        check("R7 alpha follows", 32'(c_out_a), 32'(VEC[8][59:52]));
        @(negedge clk);
        check("R7 drained", 32'(c_out_valid), 0);

        // R9: restore stall
        d_out_ready = 1'b0;
        d_in_bits = VEC[5][47:24]; d_in_len = VEC[5][51:48]; d_in_a = VEC[5][59:52];
        d_in_valid = 1'b1;
        @(negedge clk);
        d_in_bits = VEC[2][47:24]; d_in_len = VEC[2][51:48]; d_in_a = VEC[2][59:52];
        check("R9 restore ready low in stall", 32'(d_in_ready), 0);
        @(negedge clk);
        check("R9 restore held", 32'({d_out_r, d_out_g, d_out_b}), 32'(VEC[5][23:0]));
        d_out_ready = 1'b1;
        @(negedge clk);
        d_in_valid = 1'b0;
        check("R9 restore follows", 32'({d_out_r, d_out_g, d_out_b}), 32'(VEC[2][23:0]));
        @(negedge clk);

        finish_run();
    end

endmodule